// File: doc/BRIEF.md
# Processing-Element Pairing Controller

This controller decides, once per filter iteration, how up to four processing elements (numbered 0 to 3) are grouped for particle exchange after resampling. On a one-cycle iteration-start strobe it samples a 3-bit sharing mode and the four local weight sums. From these it registers three results: the set of active elements, a partner index for every element, and a flag for the all-four shared pool. It also registers the total of the local sums of the active elements. Every element uses that total to normalize its weights.

The supported groupings are as follows. One mode uses a single element and another uses two. Two modes fix the pairs. One mode swaps between two pairings on every use. One mode pairs the heaviest element with the lightest, and one mode puts all four elements in a pool with no pairs. Between strobes all results hold steady, so the elements see one grouping for the whole iteration.

Top module: `pe_pairing_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), active_mask is 0, pool_mode is 0, weight_total is 0, and every element is its own partner (partner = 8'hE4). Partner field i is partner[2i+1:2i] and holds a 0-based element index.
- R2: The outputs change only on the clock edge at which iter_start is 1. In every other cycle they hold, even if mode and local_sums change.
- R3: After a strobe, weight_total equals the sum of local_sums[16i+15:16i] over every element i whose bit is set in the new active_mask. The sum is carried to full width without wrapping.
- R4: Modes 3'b000 and 3'b110 give active_mask 4'b0001, every element as its own partner, and pool_mode 0.
- R5: Mode 3'b001 gives active_mask 4'b0011, pairs element 0 with 1, and leaves elements 2 and 3 as their own partners (partner 8'hE1).
- R6: Modes 3'b010 and 3'b011 give active_mask 4'b1111 and the pairs {0,1} and {2,3} (partner 8'hB1).
- R7: Mode 3'b100 gives active_mask 4'b1111. Its pairing alternates between {0,1},{2,3} (8'hB1) and {0,2},{1,3} (8'h4E). The alternation advances only on strobes taken in this mode. The first such strobe after reset uses {0,1},{2,3}.
- R8: Mode 3'b101 gives active_mask 4'b1111 and pairs the element with the largest local sum with the element that has the smallest local sum among the other three. The two remaining elements form the second pair. Ties go to the lower index in both choices.
- R9: Mode 3'b111 gives active_mask 4'b1111, pool_mode 1, and every element as its own partner. pool_mode is 0 in all other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iter_start | input | 1 | One-cycle strobe that starts a filter iteration |
| mode | input | 3 | Sharing mode code |
| local_sums | input | 64 | Local weight sums; element i at bits [16i+15:16i] |
| active_mask | output | 4 | Bit i set when element i takes part |
| partner | output | 8 | Partner index of element i at bits [2i+1:2i] |
| pool_mode | output | 1 | All-four shared pool with no pairs |
| weight_total | output | 18 | Total of the active elements' local sums |

## Verification
Every result, including the alternation state, is due on the first rising edge at which the strobe is high. Nothing is due later. The bench drives mode, sums and the strobe on a falling edge and drops the strobe on the next falling edge. It samples all outputs at that same falling edge, which is half a period after the edge that loaded them. For the hold cases, the bench changes the inputs with the strobe low, waits several cycles, and compares the outputs against the values from the last strobe. The reset values are sampled at a falling edge while reset is still low.

// File: rtl/pe_pair_pkg.sv
package pe_pair_pkg;

  localparam int NUM_PE = 4;
  localparam int IDX_W  = $clog2(NUM_PE);

  typedef enum logic [2:0] {
    MODE_SOLO  = 3'b000,
    MODE_DUO   = 3'b001,
    MODE_SPLIT = 3'b010,
    MODE_FIXED = 3'b011,
    MODE_ALT   = 3'b100,
    MODE_ADAPT = 3'b101,
    MODE_RSVD  = 3'b110,
    MODE_POOL  = 3'b111
  } share_mode_e;

  typedef logic [IDX_W-1:0]        pe_idx_t;
  typedef logic [NUM_PE*IDX_W-1:0] partner_vec_t;

  // every element points at itself
  function automatic partner_vec_t self_partners();
    partner_vec_t v;
    for (int i = 0; i < NUM_PE; i++) v[i*IDX_W +: IDX_W] = IDX_W'(i);
    return v;
  endfunction

  // a<->b and c<->d; an index paired with itself stays unpaired
  function automatic partner_vec_t pair_up(input pe_idx_t a, input pe_idx_t b,
                                           input pe_idx_t c, input pe_idx_t d);
    partner_vec_t v;
    v = self_partners();
    v[a*IDX_W +: IDX_W] = b;
    v[b*IDX_W +: IDX_W] = a;
    v[c*IDX_W +: IDX_W] = d;
    v[d*IDX_W +: IDX_W] = c;
    return v;
  endfunction

  function automatic pe_idx_t partner_of(input partner_vec_t v, input pe_idx_t i);
    return v[i*IDX_W +: IDX_W];
  endfunction

  function automatic logic pairs_symmetric(input partner_vec_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_PE; i++)
      if (partner_of(v, partner_of(v, IDX_W'(i))) != IDX_W'(i)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic idle_are_self(input logic [NUM_PE-1:0] m, input partner_vec_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_PE; i++)
      if (!m[i] && partner_of(v, IDX_W'(i)) != IDX_W'(i)) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/pe_rank_pick.sv
module pe_rank_pick
  import pe_pair_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic [NUM_PE*SUM_W-1:0] sums_i,
  output pe_idx_t                 hi_o,
  output pe_idx_t                 lo_o,
  output pe_idx_t                 rest_a_o,
  output pe_idx_t                 rest_b_o
);

  function automatic logic [SUM_W-1:0] sum_at(input logic [NUM_PE*SUM_W-1:0] s,
                                               input pe_idx_t i);
    return s[i*SUM_W +: SUM_W];
  endfunction

  pe_idx_t hi, lo;
  logic    got_a;

  always_comb begin
    // heaviest: strict compare keeps the lower index on ties
    hi = '0;
    for (int i = 1; i < NUM_PE; i++)
      if (sum_at(sums_i, IDX_W'(i)) > sum_at(sums_i, hi)) hi = IDX_W'(i);
    // lightest among the others, lower index on ties
    lo = (hi == '0) ? IDX_W'(1) : '0;
    for (int i = 0; i < NUM_PE; i++)
      if (IDX_W'(i) != hi && sum_at(sums_i, IDX_W'(i)) < sum_at(sums_i, lo)) lo = IDX_W'(i);
    // the two left over, ascending
    rest_a_o = '0;
    rest_b_o = '0;
    got_a    = 1'b0;
    for (int i = 0; i < NUM_PE; i++)
      if (IDX_W'(i) != hi && IDX_W'(i) != lo) begin
        if (!got_a) begin
          rest_a_o = IDX_W'(i);
          got_a    = 1'b1;
        end else begin
          rest_b_o = IDX_W'(i);
        end
      end
    hi_o = hi;
    lo_o = lo;
  end

endmodule

// File: rtl/pe_pair_decode.sv
module pe_pair_decode
  import pe_pair_pkg::*;
(
  input  share_mode_e        mode_i,
  input  logic               alt_phase_i,
  input  pe_idx_t            hi_i,
  input  pe_idx_t            lo_i,
  input  pe_idx_t            rest_a_i,
  input  pe_idx_t            rest_b_i,
  output logic [NUM_PE-1:0]  mask_o,
  output partner_vec_t       partner_o,
  output logic               pool_o
);

  always_comb begin
    mask_o    = {NUM_PE{1'b1}};
    partner_o = self_partners();
    pool_o    = 1'b0;
    unique case (mode_i)
      MODE_DUO: begin
        mask_o    = 4'b0011;
        partner_o = pair_up(2'd0, 2'd1, 2'd2, 2'd2);
      end
      MODE_SPLIT, MODE_FIXED:
        partner_o = pair_up(2'd0, 2'd1, 2'd2, 2'd3);
      MODE_ALT:
        partner_o = alt_phase_i ? pair_up(2'd0, 2'd2, 2'd1, 2'd3)
                                : pair_up(2'd0, 2'd1, 2'd2, 2'd3);
      MODE_ADAPT:
        partner_o = pair_up(hi_i, lo_i, rest_a_i, rest_b_i);
      MODE_POOL:
        pool_o = 1'b1;
      default:
        mask_o = 4'b0001;
    endcase
  end

endmodule

// File: rtl/pe_pairing_ctrl.sv
module pe_pairing_ctrl
  import pe_pair_pkg::*;
#(
  parameter int SUM_W = 16,
  localparam int TOT_W = SUM_W + $clog2(NUM_PE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iter_start,
  input  logic [2:0]              mode,
  input  logic [NUM_PE*SUM_W-1:0] local_sums,
  output logic [NUM_PE-1:0]       active_mask,
  output logic [NUM_PE*IDX_W-1:0] partner,
  output logic                    pool_mode,
  output logic [TOT_W-1:0]        weight_total
);

  function automatic logic [TOT_W-1:0] sum_active(input logic [NUM_PE*SUM_W-1:0] s,
                                                  input logic [NUM_PE-1:0] m);
    logic [TOT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_PE; i++)
      if (m[i]) acc = acc + TOT_W'(s[i*SUM_W +: SUM_W]);
    return acc;
  endfunction

  share_mode_e        mode_e;
  pe_idx_t            rk_hi, rk_lo, rk_ra, rk_rb;
  logic [NUM_PE-1:0]  dec_mask;
  partner_vec_t       dec_partner;
  logic               dec_pool;
  logic               alt_phase_q;
  logic               alt_step;

  assign mode_e   = share_mode_e'(mode);
  assign alt_step = iter_start && (mode_e == MODE_ALT);

  pe_rank_pick #(.SUM_W(SUM_W)) u_rank (
    .sums_i   (local_sums),
    .hi_o     (rk_hi),
    .lo_o     (rk_lo),
    .rest_a_o (rk_ra),
    .rest_b_o (rk_rb)
  );

  pe_pair_decode u_decode (
    .mode_i      (mode_e),
    .alt_phase_i (alt_phase_q),
    .hi_i        (rk_hi),
    .lo_i        (rk_lo),
    .rest_a_i    (rk_ra),
    .rest_b_i    (rk_rb),
    .mask_o      (dec_mask),
    .partner_o   (dec_partner),
    .pool_o      (dec_pool)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask  <= '0;
      partner      <= self_partners();
      pool_mode    <= 1'b0;
      weight_total <= '0;
      alt_phase_q  <= 1'b0;
    end else if (iter_start) begin
      active_mask  <= dec_mask;
      partner      <= dec_partner;
      pool_mode    <= dec_pool;
      weight_total <= sum_active(local_sums, dec_mask);
      if (alt_step) alt_phase_q <= ~alt_phase_q;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(iter_start) |-> $stable({active_mask, partner, pool_mode, weight_total}));

  // R7
  alt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_step |=> alt_phase_q != $past(alt_phase_q));

  // R6
  pair_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pairs_symmetric(partner));

  // R4
  idle_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_are_self(active_mask, partner));

  // R9
  pool_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_mode |-> (active_mask == {NUM_PE{1'b1}} && partner == self_partners()));

  // R8
  adapt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_start && mode_e == MODE_ADAPT) |=> partner_of(partner, $past(rk_hi)) == $past(rk_lo));

endmodule

// File: tb/pe_pairing_ctrl_bench.sv
`timescale 1ns/1ps
module pe_pairing_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iter_start = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [63:0] local_sums = '0;
  logic [3:0]  active_mask;
  logic [7:0]  partner;
  logic        pool_mode;
  logic [17:0] weight_total;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pe_pairing_ctrl u_pe_pairing_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .iter_start   (iter_start),
    .mode         (mode),
    .local_sums   (local_sums),
    .active_mask  (active_mask),
    .partner      (partner),
    .pool_mode    (pool_mode),
    .weight_total (weight_total)
  );

  // row: mode[79:77] sums{s3,s2,s1,s0}[76:13] mask[12:9] partner[8:1] pool[0]
  localparam int NVEC = 17;
  localparam logic [79:0] VEC [NVEC] = '{
    {3'b000, 16'd40, 16'd30, 16'd20, 16'd10, 4'h1, 8'hE4, 1'b0},
    {3'b110, 16'd40, 16'd30, 16'd20, 16'd10, 4'h1, 8'hE4, 1'b0},
    {3'b001, 16'd40, 16'd30, 16'd20, 16'd10, 4'h3, 8'hE1, 1'b0},
    {3'b010, 16'd40, 16'd30, 16'd20, 16'd10, 4'hF, 8'hB1, 1'b0},
    {3'b011, 16'd40, 16'd30, 16'd20, 16'd10, 4'hF, 8'hB1, 1'b0},
    {3'b100, 16'd40, 16'd30, 16'd20, 16'd10, 4'hF, 8'hB1, 1'b0},
    {3'b100, 16'd40, 16'd30, 16'd20, 16'd10, 4'hF, 8'h4E, 1'b0},
    {3'b111, 16'd40, 16'd30, 16'd20, 16'd10, 4'hF, 8'hE4, 1'b1},
    {3'b100, 16'd40, 16'd30, 16'd20, 16'd10, 4'hF, 8'hB1, 1'b0},
    {3'b101, 16'd50, 16'd7,  16'd100, 16'd5, 4'hF, 8'hB1, 1'b0},
    {3'b101, 16'd20, 16'd8,  16'd3,  16'd9,  4'hF, 8'h4E, 1'b0},
    {3'b101, 16'd50, 16'd10, 16'd10, 16'd50, 4'hF, 8'hB1, 1'b0},
    {3'b101, 16'd7,  16'd7,  16'd7,  16'd7,  4'hF, 8'hB1, 1'b0},
    {3'b101, 16'd5,  16'd20, 16'd10, 16'd60, 4'hF, 8'h1B, 1'b0},
    {3'b100, 16'd40, 16'd30, 16'd20, 16'd10, 4'hF, 8'h4E, 1'b0},
    {3'b111, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'hF, 8'hE4, 1'b1},
    {3'b001, 16'd2,  16'd1,  16'hFFFF, 16'hFFFF, 4'h3, 8'hE1, 1'b0}
  };

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'b000, 3'b110: return "R4";
      3'b001:         return "R5";
      3'b010, 3'b011: return "R6";
      3'b100:         return "R7";
      3'b101:         return "R8";
      default:        return "R9";
    endcase
  endfunction

  function automatic logic [17:0] expect_total(input logic [63:0] s, input logic [3:0] m);
    logic [17:0] t;
    t = '0;
    for (int k = 0; k < 4; k++) if (m[k]) t += {2'b00, s[16*k +: 16]};
    return t;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic [3:0] m, input logic [7:0] p,
                            input logic pl, input logic [17:0] tot);
    chk(req, "active_mask", 32'(active_mask), 32'(m));
    chk(req, "partner", 32'(partner), 32'(p));
    chk((pl || req == "R9") ? "R9" : req, "pool_mode", 32'(pool_mode), 32'(pl));
    chk("R3", "weight_total", 32'(weight_total), 32'(tot));
  endtask

  task automatic strobe(input logic [2:0] m, input logic [63:0] s);
    @(negedge clk);
    mode = m;
    local_sums = s;
    iter_start = 1'b1;
    @(negedge clk);
    iter_start = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check_outs("R1", 4'h0, 8'hE4, 1'b0, 18'd0);
    rst_n = 1'b1;

    // table walk: R3..R9
    for (int v = 0; v < NVEC; v++) begin
      strobe(VEC[v][79:77], VEC[v][76:13]);
      check_outs(mode_req(VEC[v][79:77]), VEC[v][12:9], VEC[v][8:1], VEC[v][0],
                 expect_total(VEC[v][76:13], VEC[v][12:9]));
    end

    // R2: inputs move with no strobe, outputs hold the last row
    @(negedge clk);
    mode = 3'b100;
    local_sums = {16'd1, 16'd2, 16'd3, 16'd4};
    repeat (5) @(negedge clk);
    check_outs("R2", 4'h3, 8'hE1, 1'b0, 18'd131070);

    // R7: idle cycles in alternating mode left the phase alone
    strobe(3'b100, {16'd1, 16'd2, 16'd3, 16'd4});
    check_outs("R7", 4'hF, 8'hB1, 1'b0, 18'd10);

    // R1 + R7: reset mid-run returns to the first pairing
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_outs("R1", 4'h0, 8'hE4, 1'b0, 18'd0);
    rst_n = 1'b1;
    strobe(3'b100, {16'd1, 16'd2, 16'd3, 16'd4});
    check_outs("R7", 4'hF, 8'hB1, 1'b0, 18'd10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule